// File: doc/BRIEF.md
# PTP Event Header Field Extractor

This block watches a byte-wide frame stream, such as the receive or transmit data path beside an Ethernet MAC, and finds the precision time protocol header inside each frame. The header may sit directly on Ethernet, inside IPv4/UDP, or inside IPv6/UDP, and any of the three may carry one 802.1Q tag. From the header it takes the message type, the 8-byte source clock identity, the source port number and the sequence id. It joins these with the timestamp sampled on the frame's first byte and emits one record. Software or a downstream FIFO uses that record to pair a hardware timestamp with the packet it belongs to.

Only event messages of protocol version 2 produce a record. When one-step operation is enabled, Sync and Pdelay_Resp records carry a flag. A one-step transmit path can use it to skip the two-step timestamp return for those frames.

Top module: `ptp_hdr_extract`

## Requirements
- R1: After reset, and until a qualifying frame has been fully received, `rec_valid` stays low.
- R2: With Ethertype 0x88F7 directly after the two MAC addresses, the PTP header starts at frame byte 14, and a record is produced with `rec_encap` = 1.
- R3: An 802.1Q tag (Ethertype 0x8100 at bytes 12-13) moves every later offset by 4 bytes. The tag's two control bytes are ignored, and the real Ethertype is read at bytes 16-17.
- R4: For Ethertype 0x0800 the IP version nibble must be 4. The header length is the low nibble of the first IP byte times 4, with a minimum of 5 words. The PTP header starts 8 bytes after the end of the IP header, and `rec_encap` = 2.
- R5: For Ethertype 0x86DD the PTP header starts 48 bytes after the Ethertype (40 bytes of IP and 8 of UDP), and `rec_encap` = 3.
- R6: For both IP encapsulations the protocol / next-header byte must be 17, and the UDP destination port (big-endian, bytes 2-3 of the UDP header) must be 319 or 320. Otherwise no record is produced.
- R7: The message type is the low nibble of PTP header byte 0, and the high nibble is ignored. Only types 0 (Sync), 1 (Delay_Req), 2 (Pdelay_Req) and 3 (Pdelay_Resp) produce a record.
- R8: The low nibble of PTP header byte 1 (the version) must equal 2. Frames with any other version produce no record.
- R9: `rec_clock_id` is header bytes 20-27, `rec_port` is bytes 28-29 and `rec_seq` is bytes 30-31, each taken with the first byte most significant.
- R10: `rec_valid` is a one-cycle pulse. It goes high in the cycle after the clock edge that accepts header byte 31. `rec_ts` equals the `ts_now` value sampled with the frame's first byte.
- R11: `rec_one_step` is 1 exactly when `one_step_en` was high at header byte 31 and the message type is 0 or 3.
- R12: A frame that ends, or is cut by a new start of frame, before header byte 31 has been received produces no record.
- R13: Frames with any other Ethertype produce no record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | A frame byte is present this cycle |
| in_sof | input | 1 | This byte is the first byte of a frame |
| in_byte | input | 8 | Frame byte |
| one_step_en | input | 1 | One-step operation enabled |
| ts_now | input | TS_W (48) | Free-running time value |
| rec_valid | output | 1 | Record pulse |
| rec_msg_type | output | 4 | Message type |
| rec_clock_id | output | 64 | Source clock identity |
| rec_port | output | 16 | Source port number |
| rec_seq | output | 16 | Sequence id |
| rec_ts | output | TS_W (48) | Timestamp of frame start |
| rec_encap | output | 2 | 1 layer-2, 2 IPv4/UDP, 3 IPv6/UDP |
| rec_one_step | output | 1 | One-step flag |

## Verification
A wrong offset register shows up at the ports within one frame. Either an expected record never arrives, or it carries a clock identity, port or sequence id shifted by whole bytes. A stuck or stale classification state shows up as a missing record, or as a spurious record on the next frame of another type. Both show within the 32 header bytes that follow. Each record is compared with an independently built expectation, including the exact cycle it appears in, so a one-cycle slip in the record pulse is caught at once.

// File: rtl/ptp_pkg.sv
package ptp_pkg;

  typedef enum logic [1:0] {
    ENC_NONE = 2'd0,
    ENC_L2   = 2'd1,
    ENC_V4   = 2'd2,
    ENC_V6   = 2'd3
  } encap_e;

  localparam int MAC_PAIR_LEN = 12;
  localparam int ETH_LEN      = 14;
  localparam int TAG_LEN      = 4;
  localparam int UDP_LEN      = 8;
  localparam int IP6_LEN      = 40;
  localparam int V4_PROTO_OFF = 9;
  localparam int V6_NXT_OFF   = 6;
  localparam int UDP_DPORT_LO = 3;
  localparam int HDR_SPAN     = 32;

  localparam int OFF_MSG  = 0;
  localparam int OFF_VER  = 1;
  localparam int OFF_CID  = 20;
  localparam int OFF_PORT = 28;
  localparam int OFF_SEQ  = 30;

  localparam logic [15:0] ET_TAG  = 16'h8100;
  localparam logic [15:0] ET_PTP  = 16'h88F7;
  localparam logic [15:0] ET_IPV4 = 16'h0800;
  localparam logic [15:0] ET_IPV6 = 16'h86DD;
  localparam logic [7:0]  PROTO_UDP = 8'd17;
  localparam logic [15:0] PORT_EVT  = 16'd319;
  localparam logic [15:0] PORT_GEN  = 16'd320;
  localparam logic [3:0]  PTP_VER   = 4'd2;
  localparam logic [3:0]  MSG_SYNC  = 4'd0;
  localparam logic [3:0]  MSG_PRESP = 4'd3;
  localparam logic [3:0]  MSG_LAST_EVT = 4'd3;

  typedef struct packed {
    logic [3:0]  msg;
    logic [3:0]  ver;
    logic [63:0] cid;
    logic [15:0] port;
    logic [15:0] seq;
  } hdr_fields_t;

endpackage

// File: rtl/ptp_locator.sv
module ptp_locator
  import ptp_pkg::*;
#(
  parameter int POS_W = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_valid,
  input  logic       in_sof,
  input  logic [7:0] in_byte,
  output logic       hdr_vld,
  output logic [4:0] hdr_off,
  output encap_e     encap
);
  localparam logic [POS_W-1:0] POS_MAX = '1;
  localparam logic [POS_W-1:0] SPAN    = POS_W'(HDR_SPAN);

  logic [POS_W-1:0] pos_q, pos_d, idx;
  logic             vlan_q, vlan_d, live_q, live_d, hok_q, hok_d;
  encap_e           kind_q, kind_d;
  logic [7:0]       prev_q;
  logic [POS_W-1:0] udp_q, udp_d, hb_q, hb_d;

  logic             c_vlan, c_live, c_hok;
  encap_e           c_kind;
  logic [POS_W-1:0] eh, rel;
  logic [15:0]      pair;

  // start of frame wipes the per-frame state for the byte being accepted
  assign idx    = in_sof ? '0 : pos_q;
  assign c_vlan = in_sof ? 1'b0 : vlan_q;
  assign c_live = in_sof ? 1'b1 : live_q;
  assign c_hok  = in_sof ? 1'b0 : hok_q;
  assign c_kind = in_sof ? ENC_NONE : kind_q;
  assign eh     = c_vlan ? POS_W'(ETH_LEN + TAG_LEN) : POS_W'(ETH_LEN);
  assign pair   = {prev_q, in_byte};
  assign rel    = idx - hb_q;

  always_comb begin
    pos_d  = pos_q;
    vlan_d = vlan_q;
    live_d = live_q;
    hok_d  = hok_q;
    kind_d = kind_q;
    udp_d  = udp_q;
    hb_d   = hb_q;
    if (in_valid) begin
      pos_d  = (idx == POS_MAX) ? idx : idx + 1'b1;
      vlan_d = c_vlan;
      live_d = c_live;
      hok_d  = c_hok;
      kind_d = c_kind;
      if (c_live && c_kind == ENC_NONE) begin
        if (idx == POS_W'(ETH_LEN - 1) && !c_vlan && pair == ET_TAG) begin
          vlan_d = 1'b1;
        end else if (idx == eh - 1'b1) begin
          unique case (pair)
            ET_PTP:  begin kind_d = ENC_L2; hb_d = eh; hok_d = 1'b1; end
            ET_IPV4: kind_d = ENC_V4;
            ET_IPV6: begin
              kind_d = ENC_V6;
              udp_d  = eh + POS_W'(IP6_LEN);
              hb_d   = eh + POS_W'(IP6_LEN + UDP_LEN);
              hok_d  = 1'b1;
            end
            default: live_d = 1'b0;
          endcase
        end
      end
      if (c_live && c_kind == ENC_V4) begin
        if (idx == eh) begin
          if (in_byte[7:4] != 4'd4 || in_byte[3:0] < 4'd5) live_d = 1'b0;
          udp_d = eh + POS_W'({in_byte[3:0], 2'b00});
          hb_d  = eh + POS_W'({in_byte[3:0], 2'b00}) + POS_W'(UDP_LEN);
          hok_d = 1'b1;
        end
        if (idx == eh + POS_W'(V4_PROTO_OFF) && in_byte != PROTO_UDP) live_d = 1'b0;
      end
      if (c_live && c_kind == ENC_V6 && idx == eh + POS_W'(V6_NXT_OFF) &&
          in_byte != PROTO_UDP) live_d = 1'b0;
      if (c_live && c_hok && (c_kind == ENC_V4 || c_kind == ENC_V6) &&
          idx == udp_q + POS_W'(UDP_DPORT_LO) && pair != PORT_EVT && pair != PORT_GEN)
        live_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q  <= '0;
      vlan_q <= 1'b0;
      live_q <= 1'b0;
      hok_q  <= 1'b0;
      kind_q <= ENC_NONE;
      udp_q  <= '0;
      hb_q   <= '0;
      prev_q <= '0;
    end else begin
      pos_q  <= pos_d;
      vlan_q <= vlan_d;
      live_q <= live_d;
      hok_q  <= hok_d;
      kind_q <= kind_d;
      udp_q  <= udp_d;
      hb_q   <= hb_d;
      if (in_valid) prev_q <= in_byte;
    end
  end

  assign hdr_vld = in_valid && c_live && c_hok && c_kind != ENC_NONE &&
                   idx >= hb_q && rel < SPAN;
  assign hdr_off = rel[4:0];
  assign encap   = c_kind;

  logic [4:0] last_off_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       last_off_q <= '0;
    else if (hdr_vld) last_off_q <= hdr_off;
  end

  assert_off_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hdr_vld && hdr_off != 5'd0) |-> (hdr_off == last_off_q + 5'd1));

  assert_tag_before_class_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (vlan_q && !$past(vlan_q)) |-> (kind_q == ENC_NONE));

endmodule

// File: rtl/ptp_field_cap.sv
module ptp_field_cap
  import ptp_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        hdr_vld,
  input  logic [4:0]  hdr_off,
  input  logic [7:0]  in_byte,
  output logic        hdr_done,
  output hdr_fields_t fields
);
  logic [3:0]  msg_q, msg_d, ver_q, ver_d;
  logic [63:0] cid_q, cid_d;
  logic [15:0] port_q, port_d;
  logic [7:0]  shi_q, shi_d;

  always_comb begin
    msg_d  = msg_q;
    ver_d  = ver_q;
    cid_d  = cid_q;
    port_d = port_q;
    shi_d  = shi_q;
    if (hdr_vld) begin
      if (hdr_off == 5'(OFF_MSG)) msg_d = in_byte[3:0];
      if (hdr_off == 5'(OFF_VER)) ver_d = in_byte[3:0];
      if (hdr_off >= 5'(OFF_CID) && hdr_off < 5'(OFF_PORT))
        cid_d = {cid_q[55:0], in_byte};
      if (hdr_off == 5'(OFF_PORT) || hdr_off == 5'(OFF_PORT + 1))
        port_d = {port_q[7:0], in_byte};
      if (hdr_off == 5'(OFF_SEQ)) shi_d = in_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      msg_q  <= '0;
      ver_q  <= '0;
      cid_q  <= '0;
      port_q <= '0;
      shi_q  <= '0;
    end else begin
      msg_q  <= msg_d;
      ver_q  <= ver_d;
      cid_q  <= cid_d;
      port_q <= port_d;
      shi_q  <= shi_d;
    end
  end

  assign hdr_done = hdr_vld && hdr_off == 5'(OFF_SEQ + 1);
  assign fields   = '{msg: msg_q, ver: ver_q, cid: cid_q, port: port_q,
                      seq: {shi_q, in_byte}};

endmodule

// File: rtl/ptp_rec_out.sv
module ptp_rec_out
  import ptp_pkg::*;
#(
  parameter int TS_W = 48
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [TS_W-1:0] ts_now,
  input  logic            hdr_done,
  input  hdr_fields_t     fields,
  input  encap_e          encap,
  input  logic            one_step_en,
  output logic            rec_valid,
  output logic [3:0]      rec_msg_type,
  output logic [63:0]     rec_clock_id,
  output logic [15:0]     rec_port,
  output logic [15:0]     rec_seq,
  output logic [TS_W-1:0] rec_ts,
  output logic [1:0]      rec_encap,
  output logic            rec_one_step
);
  logic [TS_W-1:0] sof_ts_q;
  logic            accept, os_d;

  assign accept = hdr_done && fields.ver == PTP_VER && fields.msg <= MSG_LAST_EVT;
  assign os_d   = one_step_en && (fields.msg == MSG_SYNC || fields.msg == MSG_PRESP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  sof_ts_q <= '0;
    else if (in_valid && in_sof) sof_ts_q <= ts_now;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rec_valid    <= 1'b0;
      rec_msg_type <= '0;
      rec_clock_id <= '0;
      rec_port     <= '0;
      rec_seq      <= '0;
      rec_ts       <= '0;
      rec_encap    <= '0;
      rec_one_step <= 1'b0;
    end else begin
      rec_valid <= accept;
      if (accept) begin
        rec_msg_type <= fields.msg;
        rec_clock_id <= fields.cid;
        rec_port     <= fields.port;
        rec_seq      <= fields.seq;
        rec_ts       <= sof_ts_q;
        rec_encap    <= encap;
        rec_one_step <= os_d;
      end
    end
  end

  assert_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |=> !rec_valid);
  assert_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> $past(hdr_done));
  assert_event_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> rec_msg_type <= MSG_LAST_EVT);
  assert_one_step_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_one_step) |-> (rec_msg_type == MSG_SYNC || rec_msg_type == MSG_PRESP));

endmodule

// File: rtl/ptp_hdr_extract.sv
module ptp_hdr_extract
  import ptp_pkg::*;
#(
  parameter int TS_W  = 48,
  parameter int POS_W = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic            in_sof,
  input  logic [7:0]      in_byte,
  input  logic            one_step_en,
  input  logic [TS_W-1:0] ts_now,
  output logic            rec_valid,
  output logic [3:0]      rec_msg_type,
  output logic [63:0]     rec_clock_id,
  output logic [15:0]     rec_port,
  output logic [15:0]     rec_seq,
  output logic [TS_W-1:0] rec_ts,
  output logic [1:0]      rec_encap,
  output logic            rec_one_step
);
  logic        hdr_vld, hdr_done;
  logic [4:0]  hdr_off;
  encap_e      encap;
  hdr_fields_t fields;

  ptp_locator #(.POS_W(POS_W)) u_loc (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .hdr_vld(hdr_vld), .hdr_off(hdr_off), .encap(encap)
  );

  ptp_field_cap u_cap (
    .clk(clk), .rst_n(rst_n), .hdr_vld(hdr_vld), .hdr_off(hdr_off),
    .in_byte(in_byte), .hdr_done(hdr_done), .fields(fields)
  );

  ptp_rec_out #(.TS_W(TS_W)) u_out (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .ts_now(ts_now), .hdr_done(hdr_done), .fields(fields), .encap(encap),
    .one_step_en(one_step_en), .rec_valid(rec_valid),
    .rec_msg_type(rec_msg_type), .rec_clock_id(rec_clock_id),
    .rec_port(rec_port), .rec_seq(rec_seq), .rec_ts(rec_ts),
    .rec_encap(rec_encap), .rec_one_step(rec_one_step)
  );

endmodule

// File: tb/ptp_hdr_extract_test.sv
module ptp_hdr_extract_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_sof = 1'b0, one_step_en = 1'b0;
  logic [7:0]  in_byte = '0;
  logic [47:0] cyc = '0;
  logic        rec_valid, rec_one_step;
  logic [3:0]  rec_msg_type;
  logic [63:0] rec_clock_id;
  logic [15:0] rec_port, rec_seq;
  logic [47:0] rec_ts;
  logic [1:0]  rec_encap;

  int checks = 0, errors = 0, unexp = 0;
  bit done = 0;

  typedef struct {
    logic [3:0]  msg;
    logic [63:0] cid;
    logic [15:0] pn, sq;
    logic [47:0] ts, at;
    logic [1:0]  enc;
    logic        os;
    string       tag;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  ptp_hdr_extract uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
    .in_byte(in_byte), .one_step_en(one_step_en), .ts_now(cyc),
    .rec_valid(rec_valid), .rec_msg_type(rec_msg_type),
    .rec_clock_id(rec_clock_id), .rec_port(rec_port), .rec_seq(rec_seq),
    .rec_ts(rec_ts), .rec_encap(rec_encap), .rec_one_step(rec_one_step)
  );

  // monitor: compare each record against the oldest expectation
  always @(negedge clk) begin
    if (rst_n && rec_valid) begin
      if (sb.size() == 0) unexp++;
      else begin
        exp_t e;
        e = sb.pop_front();
        checks++;
        if (rec_msg_type !== e.msg || rec_clock_id !== e.cid || rec_port !== e.pn ||
            rec_seq !== e.sq || rec_ts !== e.ts || cyc !== e.at ||
            rec_encap !== e.enc || rec_one_step !== e.os) begin
          errors++;
          $display("FAIL %s: got msg=%0h cid=%h port=%h seq=%h ts=%0d cyc=%0d enc=%0d os=%0b, expected msg=%0h cid=%h port=%h seq=%h ts=%0d cyc=%0d enc=%0d os=%0b",
                   e.tag, rec_msg_type, rec_clock_id, rec_port, rec_seq, rec_ts, cyc,
                   rec_encap, rec_one_step, e.msg, e.cid, e.pn, e.sq, e.ts, e.at, e.enc, e.os);
        end
      end
    end
  end

  task automatic check_clean(input string tag);
    checks++;
    if (sb.size() != 0 || unexp != 0) begin
      errors++;
      $display("FAIL %s: missing=%0d unexpected=%0d, expected missing=0 unexpected=0",
               tag, sb.size(), unexp);
    end
    sb.delete();
    unexp = 0;
  endtask

  // enc: 1 layer-2, 2 IPv4, 3 IPv6, 0 raw Ethertype et
  task automatic send_frame(input int enc, input bit vlan, input int ihl,
                            input int dport, input int proto, input logic [7:0] msgb,
                            input logic [7:0] verb, input logic [63:0] cid,
                            input logic [15:0] pn, input logic [15:0] sq,
                            input int cut, input bit gap, input bit exp,
                            input logic [15:0] et, input string tag);
    logic [7:0] fb[$];
    int hs;
    exp_t e;
    logic [47:0] sof_c;
    for (int i = 0; i < 12; i++) fb.push_back(8'hA0 + 8'(i));
    if (vlan) begin fb.push_back(8'h81); fb.push_back(8'h00); fb.push_back(8'h20); fb.push_back(8'h05); end
    case (enc)
      1: et = 16'h88F7;
      2: et = 16'h0800;
      3: et = 16'h86DD;
      default: ;
    endcase
    fb.push_back(et[15:8]); fb.push_back(et[7:0]);
    if (enc == 2) begin
      fb.push_back(8'h40 | 8'(ihl));
      for (int i = 1; i < ihl * 4; i++) fb.push_back(i == 9 ? 8'(proto) : 8'h11);
    end
    if (enc == 3) begin
      fb.push_back(8'h60);
      for (int i = 1; i < 40; i++) fb.push_back(i == 6 ? 8'(proto) : 8'h22);
    end
    if (enc == 2 || enc == 3) begin
      fb.push_back(8'h01); fb.push_back(8'h3F);
      fb.push_back(8'(dport >> 8)); fb.push_back(8'(dport));
      for (int i = 0; i < 4; i++) fb.push_back(8'h00);
    end
    hs = fb.size();
    for (int i = 0; i < 34; i++) begin
      logic [7:0] b;
      b = 8'h33;
      if (i == 0) b = msgb;
      if (i == 1) b = verb;
      if (i >= 20 && i < 28) b = cid[8*(27-i) +: 8];
      if (i == 28) b = pn[15:8];
      if (i == 29) b = pn[7:0];
      if (i == 30) b = sq[15:8];
      if (i == 31) b = sq[7:0];
      fb.push_back(b);
    end
    for (int i = 0; i < 6; i++) fb.push_back(8'h5A);
    if (cut > 0) while (fb.size() > cut) void'(fb.pop_back());
    sof_c = '0;
    for (int i = 0; i < fb.size(); i++) begin
      @(negedge clk);
      if (gap && i == hs + 10) begin
        in_valid = 1'b0; in_sof = 1'b0;
        @(negedge clk);
      end
      in_valid = 1'b1;
      in_sof   = (i == 0);
      in_byte  = fb[i];
      if (i == 0) sof_c = cyc;
      if (exp && i == hs + 31) begin
        e.msg = msgb[3:0]; e.cid = cid; e.pn = pn; e.sq = sq; e.ts = sof_c;
        e.at = cyc + 1; e.enc = 2'(enc);
        e.os = one_step_en && (msgb[3:0] == 4'd0 || msgb[3:0] == 4'd3);
        e.tag = tag;
        sb.push_back(e);
      end
    end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (rec_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rec_valid=%b in reset, expected 0", rec_valid);
    end
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    checks++;
    if (rec_valid !== 1'b0) begin
      errors++; $display("FAIL R1: rec_valid=%b after reset, expected 0", rec_valid);
    end

    send_frame(1, 0, 0, 0, 0, 8'h00, 8'h02, 64'h0011223344556677, 16'h0102, 16'h0A0B, 0, 0, 1, 0, "R2 R9 R10 layer-2 Sync");
    check_clean("R2");
    send_frame(1, 1, 0, 0, 0, 8'h11, 8'h12, 64'hFEDCBA9876543210, 16'h8001, 16'hFFFE, 0, 0, 1, 0, "R3 R7 tagged Delay_Req high nibble");
    check_clean("R3");
    send_frame(2, 0, 5, 319, 17, 8'h02, 8'h02, 64'h1122334455667788, 16'h0003, 16'h1234, 0, 0, 1, 0, "R4 IPv4 IHL5 port 319");
    check_clean("R4");
    send_frame(2, 0, 6, 320, 17, 8'h03, 8'h02, 64'hA1A2A3A4A5A6A7A8, 16'h0004, 16'h4321, 0, 1, 1, 0, "R4 R10 IPv4 IHL6 port 320 gap");
    check_clean("R4");
    send_frame(3, 1, 0, 319, 17, 8'h00, 8'h02, 64'h0F0E0D0C0B0A0908, 16'h0055, 16'h0001, 0, 0, 1, 0, "R5 R3 tagged IPv6");
    check_clean("R5");
    send_frame(2, 0, 5, 321, 17, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 0, "R6");
    check_clean("R6 wrong UDP port");
    send_frame(2, 0, 5, 319, 6, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 0, "R6");
    check_clean("R6 not UDP");
    send_frame(3, 0, 0, 319, 6, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 0, "R6");
    check_clean("R6 IPv6 not UDP");
    send_frame(1, 0, 0, 0, 0, 8'h08, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 0, "R7");
    check_clean("R7 type 8 ignored");
    send_frame(1, 0, 0, 0, 0, 8'h00, 8'h01, 64'h1, 16'h1, 16'h1, 0, 0, 0, 0, "R8");
    check_clean("R8 version 1 ignored");
    one_step_en = 1'b1;
    send_frame(1, 0, 0, 0, 0, 8'h00, 8'h02, 64'h0101010101010101, 16'h0007, 16'h0100, 0, 0, 1, 0, "R11 one-step Sync");
    send_frame(2, 0, 5, 319, 17, 8'h01, 8'h02, 64'h0202020202020202, 16'h0008, 16'h0101, 0, 0, 1, 0, "R11 one-step Delay_Req");
    send_frame(3, 0, 0, 320, 17, 8'h03, 8'h02, 64'h0303030303030303, 16'h0009, 16'h0102, 0, 0, 1, 0, "R11 one-step Pdelay_Resp");
    check_clean("R11");
    one_step_en = 1'b0;
    send_frame(1, 0, 0, 0, 0, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 14 + 31, 0, 0, 0, "R12");
    check_clean("R12 truncated");
    send_frame(1, 0, 0, 0, 0, 8'h02, 8'h02, 64'h7777666655554444, 16'h0ABC, 16'h0DEF, 0, 0, 1, 0, "R12 frame after truncated");
    check_clean("R12");
    send_frame(0, 0, 0, 0, 0, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 16'h0806, "R13");
    check_clean("R13 other Ethertype");
    send_frame(0, 1, 0, 0, 0, 8'h00, 8'h02, 64'h1, 16'h1, 16'h1, 0, 0, 0, 16'h9000, "R13");
    check_clean("R13 tagged other Ethertype");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule